// File: doc/BRIEF.md
# Keyed Unlock and Boot-Bank Switch Controller

This block protects an eight-bit chip-control register behind a two-byte key sequence. It also decides which code bank the processor fetches from. The block watches a simple write bus. Writes to a key address drive an unlock sequencer. Writes to the control address land in the register only while that sequencer reports the unlocked state. Outside that state the register reads back its old value and cannot be changed.

Setting the arm bit of the control register does not switch banks straight away. The switch waits for the next wake-from-idle strobe from the processor. On that wake the block moves fetch from the large application bank to the small loader bank. In the same cycle it pulses two requests: one that clears the program counter, and one that makes the core push a zero return address onto the stack. Because of that pushed address, the first return-from-interrupt executed in the loader lands at loader address zero.

An unlocked write with a chosen reset pattern makes the block emit a software-reset pulse of fixed length. The same write relocks the sequencer, clears the register and sends fetch back to the application bank.

Top module: `boot_bank_ctl`

## Requirements
- R1: After reset, `ctl_q` is 00H and `unlocked`, `bank_sel`, `pc_clear`, `stack_push` and `sw_reset` are all 0.
- R2: While `unlocked` is 0, a write to `CTL_ADDR` (default C5H) leaves `ctl_q` unchanged and starts no software reset.
- R3: A write of 87H followed by a write of 59H to `KEY_ADDR` (default C6H) raises `unlocked` in the cycle after the second write. A later write to `CTL_ADDR` then shows up on `ctl_q` in the cycle after it.
- R4: Once `unlocked` is 1, any key write ends it. A key write of 87H starts a new sequence. Any other value returns the sequencer to idle. After 87H, a key write other than 59H and 87H returns the sequencer to idle, so a following 59H does not unlock. A repeated 87H restarts the sequence. The order 59H then 87H does not unlock.
- R5: Setting bit 0 of `ctl_q` (the arm bit) does not change `bank_sel` by itself.
- R6: A `wake` strobe while bit 0 of `ctl_q` is 1 and `bank_sel` is 0 (the application bank) sets `bank_sel` to 1 (the loader bank) in the next cycle. In that same cycle `pc_clear` and `stack_push` are both high for exactly one cycle.
- R7: A `wake` strobe has no effect while bit 0 of `ctl_q` is 0, or while `bank_sel` is already 1.
- R8: An unlocked write to `CTL_ADDR` whose data has bits 7, 1 and 0 all set causes several things. `sw_reset` goes high in the next cycle and stays high for exactly `SRST_LEN` (default 4) cycles. In that same next cycle `ctl_q` reads 00H, `unlocked` is 0 and `bank_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data |
| wake | input | 1 | One-cycle wake-from-idle strobe |
| ctl_q | output | DATA_W | Control register contents |
| unlocked | output | 1 | Control register currently writable |
| bank_sel | output | 1 | Fetch bank: 0 application, 1 loader |
| pc_clear | output | 1 | One-cycle program-counter clear request |
| stack_push | output | 1 | One-cycle request to push a zero return address |
| sw_reset | output | 1 | Software-reset pulse to the core |

## Verification
The hardest state to reach from the ports is a sequencer that was taken back to idle by the wrong second byte. Proving it is idle needs more than one write. The stimulus first writes 87H and then a stray byte. It then writes 59H and shows that `unlocked` stays low. It also writes 87H twice before 59H, to show that the sequence restarts. A second hard point is the wake strobe. It is applied only after arming, and then again once the loader bank is already selected, to show that it is ignored. The software-reset pulse is counted cycle by cycle to check its edges.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
   typedef enum logic [1:0] {
      KS_IDLE = 2'd0,
      KS_HALF = 2'd1,
      KS_OPEN = 2'd2
   } key_st_e;
endpackage

// File: rtl/bbc_key_seq.sv
module bbc_key_seq
   import bbc_pkg::*;
#(
   parameter int                DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY1   = 8'h87,
   parameter logic [DATA_W-1:0] KEY2   = 8'h59
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_data,
   input  logic              clr,
   output logic              open
);
   key_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (clr) begin
         st_d = KS_IDLE;
      end else if (key_wr) begin
         case (st_q)
            KS_HALF: begin
               if (key_data == KEY2)      st_d = KS_OPEN;
               else if (key_data == KEY1) st_d = KS_HALF;
               else                       st_d = KS_IDLE;
            end
            default: st_d = (key_data == KEY1) ? KS_HALF : KS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KS_IDLE;
      else        st_q <= st_d;
   end

   assign open = (st_q == KS_OPEN);
endmodule

// File: rtl/bbc_ctl_reg.sv
module bbc_ctl_reg #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] SRST_MASK = 8'h83
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_data,
   input  logic              open,
   output logic [DATA_W-1:0] ctl_q,
   output logic              srst_req
);
   logic wr_ok;

   assign wr_ok    = ctl_wr && open;
   assign srst_req = wr_ok && ((ctl_data & SRST_MASK) == SRST_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctl_q <= '0;
      else if (srst_req) ctl_q <= '0;
      else if (wr_ok)    ctl_q <= ctl_data;
   end
endmodule

// File: rtl/bbc_bank_ctl.sv
module bbc_bank_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wake,
   input  logic arm,
   input  logic srst_req,
   output logic bank_sel,
   output logic isp_pulse
);
   logic enter;

   assign enter = wake && arm && !bank_sel && !srst_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_sel  <= 1'b0;
         isp_pulse <= 1'b0;
      end else begin
         isp_pulse <= enter;
         if (srst_req)   bank_sel <= 1'b0;
         else if (enter) bank_sel <= 1'b1;
      end
   end
endmodule

// File: rtl/bbc_rst_pulse.sv
module bbc_rst_pulse #(
   parameter int SRST_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   generate
      if (SRST_LEN == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) active <= 1'b0;
            else        active <= start;
         end
      end else begin : g_count
         localparam int CW = $clog2(SRST_LEN + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (start)        cnt_q <= CW'(SRST_LEN);
            else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         end
         assign active = (cnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/boot_bank_ctl.sv
module boot_bank_ctl #(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hC6,
   parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'hC5,
   parameter logic [DATA_W-1:0] KEY1      = 8'h87,
   parameter logic [DATA_W-1:0] KEY2      = 8'h59,
   parameter logic [DATA_W-1:0] SRST_MASK = 8'h83,
   parameter int                SRST_LEN  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wake,
   output logic [DATA_W-1:0] ctl_q,
   output logic              unlocked,
   output logic              bank_sel,
   output logic              pc_clear,
   output logic              stack_push,
   output logic              sw_reset
);
   generate
      if (SRST_LEN < 1) begin : g_bad_len
         $error("SRST_LEN must be at least 1");
      end
      if (KEY1 == KEY2) begin : g_bad_key
         $error("KEY1 and KEY2 must differ");
      end
      if (KEY_ADDR == CTL_ADDR) begin : g_bad_addr
         $error("KEY_ADDR and CTL_ADDR must differ");
      end
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic key_wr, ctl_wr, srst_req, isp_pulse;

   assign key_wr = wr_en && (wr_addr == KEY_ADDR);
   assign ctl_wr = wr_en && (wr_addr == CTL_ADDR);

   bbc_key_seq #(.DATA_W(DATA_W), .KEY1(KEY1), .KEY2(KEY2)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .key_data (wr_data),
      .clr      (srst_req || sw_reset),
      .open     (unlocked)
   );

   bbc_ctl_reg #(.DATA_W(DATA_W), .SRST_MASK(SRST_MASK)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (ctl_wr),
      .ctl_data (wr_data),
      .open     (unlocked),
      .ctl_q    (ctl_q),
      .srst_req (srst_req)
   );

   bbc_bank_ctl u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wake      (wake),
      .arm       (ctl_q[0]),
      .srst_req  (srst_req),
      .bank_sel  (bank_sel),
      .isp_pulse (isp_pulse)
   );

   bbc_rst_pulse #(.SRST_LEN(SRST_LEN)) u_rst (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (srst_req),
      .active (sw_reset)
   );

   assign pc_clear   = isp_pulse;
   assign stack_push = isp_pulse;
endmodule

// File: rtl/bbc_chk.sv
module bbc_chk #(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hC6,
   parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'hC5,
   parameter logic [DATA_W-1:0] KEY2      = 8'h59,
   parameter int                SRST_LEN  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              wake,
   input logic [DATA_W-1:0] ctl_q,
   input logic              unlocked,
   input logic              bank_sel,
   input logic              pc_clear,
   input logic              stack_push,
   input logic              sw_reset
);
   localparam int RW = $clog2(SRST_LEN + 2) + 1;
   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 run_q <= '0;
      else if (!sw_reset)         run_q <= '0;
      else if (run_q < RW'(SRST_LEN + 1)) run_q <= run_q + 1'b1;
   end

   // R2
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && wr_en && wr_addr == CTL_ADDR) |=> $stable(ctl_q));

   // R3
   unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(wr_en && wr_addr == KEY_ADDR && wr_data == KEY2));

   // R6
   entry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_sel) |-> (pc_clear && stack_push));

   // R6
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_clear |=> !pc_clear);

   // R7
   wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && !ctl_q[0]) |=> !stack_push);

   // R8
   srst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_reset) |-> (run_q == RW'(SRST_LEN)));

   // R8
   srst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_reset) |-> (ctl_q == '0 && !bank_sel && !unlocked));
endmodule

bind boot_bank_ctl bbc_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
   .CTL_ADDR(CTL_ADDR), .KEY2(KEY2), .SRST_LEN(SRST_LEN)
) u_bbc_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .wake(wake), .ctl_q(ctl_q), .unlocked(unlocked),
   .bank_sel(bank_sel), .pc_clear(pc_clear), .stack_push(stack_push),
   .sw_reset(sw_reset)
);

// File: tb/test_boot_bank_ctl.sv
module test_boot_bank_ctl;
   localparam logic [7:0] KA = 8'hC6;
   localparam logic [7:0] CA = 8'hC5;

   typedef struct {
      string      req;
      int         due;
      logic [7:0] ctl;
      logic       unl;
      logic       bank;
      logic       pulse;
      logic       srst;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       wake = 1'b0;
   logic [7:0] ctl_q;
   logic       unlocked, bank_sel, pc_clear, stack_push, sw_reset;

   int   n_run = 0;
   int   n_fail = 0;
   int   cycnt = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cycnt <= cycnt + 1;

   boot_bank_ctl i_boot_bank_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wake(wake), .ctl_q(ctl_q), .unlocked(unlocked),
      .bank_sel(bank_sel), .pc_clear(pc_clear), .stack_push(stack_push),
      .sw_reset(sw_reset)
   );

   // driver: apply one cycle of stimulus and queue the expected outcome
   task automatic cyc(input bit we, input logic [7:0] a, input logic [7:0] d,
                      input bit wk, input logic [7:0] e_ctl, input bit e_unl,
                      input bit e_bank, input bit e_pulse, input bit e_srst,
                      input string req);
      exp_t e;
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; wake = wk;
      e.req = req; e.due = cycnt + 1; e.ctl = e_ctl; e.unl = e_unl;
      e.bank = e_bank; e.pulse = e_pulse; e.srst = e_srst;
      q.push_back(e);
   endtask

   // monitor: compare outputs against queued items when they fall due
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due <= cycnt) begin
         exp_t e;
         e = q.pop_front();
         n_run++;
         if (ctl_q !== e.ctl || unlocked !== e.unl || bank_sel !== e.bank ||
             pc_clear !== e.pulse || stack_push !== e.pulse || sw_reset !== e.srst) begin
            n_fail++;
            $display("FAIL %s: got ctl=%h unl=%b bank=%b pc=%b push=%b srst=%b, expected ctl=%h unl=%b bank=%b pulse=%b srst=%b",
                     e.req, ctl_q, unlocked, bank_sel, pc_clear, stack_push, sw_reset,
                     e.ctl, e.unl, e.bank, e.pulse, e.srst);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      n_run++;
      if (ctl_q !== 8'h00 || unlocked !== 1'b0 || bank_sel !== 1'b0 ||
          pc_clear !== 1'b0 || stack_push !== 1'b0 || sw_reset !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: reset outputs ctl=%h unl=%b bank=%b srst=%b, expected all zero",
                  ctl_q, unlocked, bank_sel, sw_reset);
      end
      rst_n = 1'b1;
      cyc(0, 8'h00, 8'h00, 0, 8'h00, 0, 0, 0, 0, "R1");
      cyc(1, CA,    8'h01, 0, 8'h00, 0, 0, 0, 0, "R2");
      cyc(1, KA,    8'h87, 0, 8'h00, 0, 0, 0, 0, "R3");
      cyc(1, KA,    8'h59, 0, 8'h00, 1, 0, 0, 0, "R3");
      cyc(1, CA,    8'h01, 0, 8'h01, 1, 0, 0, 0, "R3");
      cyc(0, 8'h00, 8'h00, 0, 8'h01, 1, 0, 0, 0, "R5");
      cyc(0, 8'h00, 8'h00, 1, 8'h01, 1, 1, 1, 0, "R6");
      cyc(0, 8'h00, 8'h00, 0, 8'h01, 1, 1, 0, 0, "R6");
      cyc(0, 8'h00, 8'h00, 1, 8'h01, 1, 1, 0, 0, "R7");
      cyc(1, KA,    8'h00, 0, 8'h01, 0, 1, 0, 0, "R4");
      cyc(1, CA,    8'h83, 0, 8'h01, 0, 1, 0, 0, "R2");
      cyc(1, KA,    8'h87, 0, 8'h01, 0, 1, 0, 0, "R4");
      cyc(1, KA,    8'h87, 0, 8'h01, 0, 1, 0, 0, "R4");
      cyc(1, KA,    8'h59, 0, 8'h01, 1, 1, 0, 0, "R4");
      cyc(1, KA,    8'h87, 0, 8'h01, 0, 1, 0, 0, "R4");
      cyc(1, KA,    8'h12, 0, 8'h01, 0, 1, 0, 0, "R4");
      cyc(1, KA,    8'h59, 0, 8'h01, 0, 1, 0, 0, "R4");
      cyc(1, KA,    8'h87, 0, 8'h01, 0, 1, 0, 0, "R3");
      cyc(1, KA,    8'h59, 0, 8'h01, 1, 1, 0, 0, "R3");
      cyc(1, CA,    8'h83, 0, 8'h00, 0, 0, 0, 1, "R8");
      cyc(0, 8'h00, 8'h00, 0, 8'h00, 0, 0, 0, 1, "R8");
      cyc(0, 8'h00, 8'h00, 0, 8'h00, 0, 0, 0, 1, "R8");
      cyc(0, 8'h00, 8'h00, 0, 8'h00, 0, 0, 0, 1, "R8");
      cyc(0, 8'h00, 8'h00, 0, 8'h00, 0, 0, 0, 0, "R8");
      cyc(0, 8'h00, 8'h00, 1, 8'h00, 0, 0, 0, 0, "R7");
      cyc(1, KA,    8'h59, 0, 8'h00, 0, 0, 0, 0, "R4");
      cyc(1, KA,    8'h87, 0, 8'h00, 0, 0, 0, 0, "R4");
      cyc(1, CA,    8'h01, 0, 8'h00, 0, 0, 0, 0, "R2");
      cyc(0, 8'h00, 8'h00, 0, 8'h00, 0, 0, 0, 0, "R2");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule